// File: doc/BRIEF.md
# Address-masked GPIO port controller

This block is an eight-pin general-purpose I/O port driven over a simple byte-wide register bus. A bus access carries a byte offset, a write or read strobe and, for writes, a data byte. The low kilobyte of the map is a data window. The offset's bits [9:2] form a per-pin mask, so one write can set or clear any subset of pins and leave the other pins unchanged. Software does not need a read-modify-write sequence for this. Reads through the window use the same mask and return zero for the pins that are not selected.

A direction register chooses, per pin, whether the port drives the pad. The output value latch of a pin only takes data while that pin is an output. Pad inputs pass through a two-flop synchronizer. The synchronized value is readable through the window and is also exported to a separate edge and level detection block. The interrupt configuration registers, the raw and masked status views and the write-to-clear register live in this block's map and are exchanged with that detector over dedicated ports.

Top module: `gpio_port`

## Requirements
- R1: After reset, the direction latch, the output value latch and all four interrupt configuration registers are 0. `padOe`, `padOut`, `intClear` and `rdData` are 0.
- R2: A write at offset 0x400 loads the direction register (1 = drive the pin). `padOe` shows the new value in the cycle after the write, and a read at 0x400 returns it.
- R3: A write at a data window offset (offset below 0x400 with bits [1:0] = 0) loads the output latch of pin n from data bit n only when offset bit n+2 is 1 and pin n is an output. The other latch bits keep their value. `padOut` presents the latch.
- R4: A data write leaves the latch bit of an input pin unchanged. Switching that pin to output afterwards drives the old latch value.
- R5: A data window read returns 0 for pin n when offset bit n+2 is 0. For a selected pin it returns the latch bit if the pin is an output, and the synchronized pad bit if the pin is an input.
- R6: A change on `padIn` appears on `syncIn` exactly two clock edges later.
- R7: The interrupt configuration registers are read/write: sense at 0x404, both-edge at 0x408, event polarity at 0x40C, enable at 0x410. They drive `cfgSense`, `cfgBoth`, `cfgEvent` and `cfgEnable`.
- R8: A read at 0x414 returns `intRaw`. A read at 0x418 returns `intRaw & cfgEnable`. Writes to either offset change no register.
- R9: A write at 0x41C drives `intClear` with the written byte for exactly one cycle, in the cycle after the write. A read at 0x41C returns 0.
- R10: An access at an unmapped offset has no effect on writes and returns 0 on reads. Unmapped offsets are 0x420 and above, and any offset with bits [1:0] not 0.
- R11: `rdData` holds the result of a read in the cycle after `rdEn`. In every cycle that follows a cycle with no read, `rdData` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | 12 | Byte offset of the access |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, valid the cycle after `rdEn` |
| padIn | input | 8 | Asynchronous pad input levels |
| padOut | output | 8 | Pad output values |
| padOe | output | 8 | Pad output enables |
| syncIn | output | 8 | Synchronized pad inputs, for the detector |
| cfgSense | output | 8 | Level/edge sense select per pin |
| cfgBoth | output | 8 | Both-edge select per pin |
| cfgEvent | output | 8 | Event polarity per pin |
| cfgEnable | output | 8 | Interrupt enable per pin |
| intRaw | input | 8 | Raw interrupt status from the detector |
| intClear | output | 8 | One-cycle clear pulse per pin |

## Verification
The hardest situation to reach from the ports is a masked write whose mask, the direction setting and the current latch content all disagree bit by bit. Only that case shows whether the input-pin guard and the address mask are combined per pin. The stimulus sweeps all 256 window masks under four direction patterns, including mixed ones. The latch value carries over from one write to the next, so the later writes land on the history the earlier ones left. Each write is followed by a window read with a different mask. That read compares driven and synchronized pins against a bench model in the same pass.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  // Read source selected by the decoder
  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_DATA,
    SEL_DIR,
    SEL_SENSE,
    SEL_BOTH,
    SEL_EVENT,
    SEL_ENABLE,
    SEL_RAW,
    SEL_MASKED
  } rdSel_e;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic   wrData;
    logic   wrDir;
    logic   wrSense;
    logic   wrBoth;
    logic   wrEvent;
    logic   wrEnable;
    logic   wrClear;
    logic   rdStrobe;
    rdSel_e rdSel;
  } strobe_t;

  // Word index inside the register block (offset bits [4:2])
  localparam logic [2:0] IDX_DIR    = 3'd0;
  localparam logic [2:0] IDX_SENSE  = 3'd1;
  localparam logic [2:0] IDX_BOTH   = 3'd2;
  localparam logic [2:0] IDX_EVENT  = 3'd3;
  localparam logic [2:0] IDX_ENABLE = 3'd4;
  localparam logic [2:0] IDX_RAW    = 3'd5;
  localparam logic [2:0] IDX_MASKED = 3'd6;
  localparam logic [2:0] IDX_CLEAR  = 3'd7;

endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 12
) (
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [ADDR_W-1:0]   addr,
  output strobe_t             strobe,
  output logic [NUM_PINS-1:0] pinMask
);

  // The window occupies offsets below 1 << WIN_TOP; registers follow it
  localparam int WIN_TOP = NUM_PINS + 2;
  localparam int TAG_W   = ADDR_W - 5;
  localparam logic [TAG_W-1:0] REG_TAG = TAG_W'(1 << (WIN_TOP - 5));

  logic       aligned;
  logic       winHit;
  logic       regHit;
  logic [2:0] regIdx;

  assign aligned = (addr[1:0] == 2'b00);
  assign winHit  = aligned && (addr[ADDR_W-1:WIN_TOP] == '0);
  assign regHit  = aligned && (addr[ADDR_W-1:5] == REG_TAG);
  assign regIdx  = addr[4:2];
  assign pinMask = addr[WIN_TOP-1:2];

  always_comb begin
    strobe          = '0;
    strobe.rdSel    = SEL_NONE;
    strobe.rdStrobe = rdEn;
    if (winHit) begin
      strobe.wrData = wrEn;
      strobe.rdSel  = SEL_DATA;
    end else if (regHit) begin
      unique case (regIdx)
        IDX_DIR: begin
          strobe.wrDir = wrEn;
          strobe.rdSel = SEL_DIR;
        end
        IDX_SENSE: begin
          strobe.wrSense = wrEn;
          strobe.rdSel   = SEL_SENSE;
        end
        IDX_BOTH: begin
          strobe.wrBoth = wrEn;
          strobe.rdSel  = SEL_BOTH;
        end
        IDX_EVENT: begin
          strobe.wrEvent = wrEn;
          strobe.rdSel   = SEL_EVENT;
        end
        IDX_ENABLE: begin
          strobe.wrEnable = wrEn;
          strobe.rdSel    = SEL_ENABLE;
        end
        IDX_RAW:    strobe.rdSel = SEL_RAW;
        IDX_MASKED: strobe.rdSel = SEL_MASKED;
        IDX_CLEAR:  strobe.wrClear = wrEn;
        default:    strobe.rdSel = SEL_NONE;
      endcase
    end
  end

endmodule

// File: rtl/gpio_port_dp.sv
module gpio_port_dp
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strobe,
  input  logic [NUM_PINS-1:0] pinMask,
  input  logic [NUM_PINS-1:0] wrData,
  input  logic [NUM_PINS-1:0] padIn,
  input  logic [NUM_PINS-1:0] intRaw,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] syncIn,
  output logic [NUM_PINS-1:0] cfgSense,
  output logic [NUM_PINS-1:0] cfgBoth,
  output logic [NUM_PINS-1:0] cfgEvent,
  output logic [NUM_PINS-1:0] cfgEnable,
  output logic [NUM_PINS-1:0] intClear,
  output logic [NUM_PINS-1:0] rdData
);

  logic [NUM_PINS-1:0] dirReg;
  logic [NUM_PINS-1:0] outLatch;
  logic [NUM_PINS-1:0] winView;
  logic [NUM_PINS-1:0] rdMux;
  logic [NUM_PINS-1:0] syncChain [SYNC_STAGES];

  // Input synchronizer chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain[0] <= '0;
    else       syncChain[0] <= padIn;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncChain[s] <= '0;
      else       syncChain[s] <= syncChain[s-1];
    end
  end

  assign syncIn = syncChain[SYNC_STAGES-1];

  // Per-pin output latch and window read view
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        outLatch[p] <= 1'b0;
      else if (strobe.wrData && pinMask[p] && dirReg[p])
        outLatch[p] <= wrData[p];
    end
    assign winView[p] = pinMask[p] & (dirReg[p] ? outLatch[p] : syncIn[p]);
  end

  // Direction and interrupt configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg    <= '0;
      cfgSense  <= '0;
      cfgBoth   <= '0;
      cfgEvent  <= '0;
      cfgEnable <= '0;
    end else begin
      if (strobe.wrDir)    dirReg    <= wrData;
      if (strobe.wrSense)  cfgSense  <= wrData;
      if (strobe.wrBoth)   cfgBoth   <= wrData;
      if (strobe.wrEvent)  cfgEvent  <= wrData;
      if (strobe.wrEnable) cfgEnable <= wrData;
    end
  end

  // One-cycle clear pulse toward the detector
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              intClear <= '0;
    else if (strobe.wrClear) intClear <= wrData;
    else                    intClear <= '0;
  end

  always_comb begin
    unique case (strobe.rdSel)
      SEL_DATA:   rdMux = winView;
      SEL_DIR:    rdMux = dirReg;
      SEL_SENSE:  rdMux = cfgSense;
      SEL_BOTH:   rdMux = cfgBoth;
      SEL_EVENT:  rdMux = cfgEvent;
      SEL_ENABLE: rdMux = cfgEnable;
      SEL_RAW:    rdMux = intRaw;
      SEL_MASKED: rdMux = intRaw & cfgEnable;
      default:    rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               rdData <= '0;
    else if (strobe.rdStrobe) rdData <= rdMux;
    else                     rdData <= '0;
  end

  assign padOut = outLatch;
  assign padOe  = dirReg;

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [NUM_PINS-1:0] wrData,
  output logic [NUM_PINS-1:0] rdData,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] syncIn,
  output logic [NUM_PINS-1:0] cfgSense,
  output logic [NUM_PINS-1:0] cfgBoth,
  output logic [NUM_PINS-1:0] cfgEvent,
  output logic [NUM_PINS-1:0] cfgEnable,
  input  logic [NUM_PINS-1:0] intRaw,
  output logic [NUM_PINS-1:0] intClear
);

  strobe_t             strobe;
  logic [NUM_PINS-1:0] pinMask;

  gpio_port_ctrl #(
    .NUM_PINS(NUM_PINS),
    .ADDR_W  (ADDR_W)
  ) u_ctrl (
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .addr   (addr),
    .strobe (strobe),
    .pinMask(pinMask)
  );

  gpio_port_dp #(
    .NUM_PINS   (NUM_PINS),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .pinMask  (pinMask),
    .wrData   (wrData),
    .padIn    (padIn),
    .intRaw   (intRaw),
    .padOut   (padOut),
    .padOe    (padOe),
    .syncIn   (syncIn),
    .cfgSense (cfgSense),
    .cfgBoth  (cfgBoth),
    .cfgEvent (cfgEvent),
    .cfgEnable(cfgEnable),
    .intClear (intClear),
    .rdData   (rdData)
  );

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int NUM_PINS    = 8,
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input logic                clk,
  input logic                rstN,
  input logic                wrEn,
  input logic                rdEn,
  input logic [ADDR_W-1:0]   addr,
  input logic [NUM_PINS-1:0] wrData,
  input logic [NUM_PINS-1:0] rdData,
  input logic [NUM_PINS-1:0] padIn,
  input logic [NUM_PINS-1:0] padOut,
  input logic [NUM_PINS-1:0] padOe,
  input logic [NUM_PINS-1:0] syncIn,
  input logic [NUM_PINS-1:0] cfgSense,
  input logic [NUM_PINS-1:0] cfgBoth,
  input logic [NUM_PINS-1:0] cfgEvent,
  input logic [NUM_PINS-1:0] cfgEnable,
  input logic [NUM_PINS-1:0] intRaw,
  input logic [NUM_PINS-1:0] intClear
);

  localparam logic [ADDR_W-1:0] DIR_OFS   = ADDR_W'(1 << (NUM_PINS + 2));
  localparam logic [ADDR_W-1:0] CLEAR_OFS = DIR_OFS + ADDR_W'(28);
  localparam logic [ADDR_W-1:0] END_OFS   = DIR_OFS + ADDR_W'(32);

  logic [1:0] upCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              upCnt <= '0;
    else if (upCnt != 2'd2) upCnt <= upCnt + 2'd1;
  end

  // R2: direction write reaches the pad enables one cycle later
  a_r2_oe_follows_dir: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == DIR_OFS) |=> (padOe == $past(wrData)));

  // R4: pins that were inputs never change their driven value
  a_r4_input_pin_hold: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (((padOut ^ $past(padOut)) & ~$past(padOe)) == '0));

  // R9: no clear pulse without a write to the clear offset
  a_r9_clear_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && addr == CLEAR_OFS) |=> (intClear == '0));

  // R10: writes above the register block leave configuration alone
  a_r10_unmapped_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr >= END_OFS) |=> ($stable(padOe) && $stable(cfgEnable) && $stable(padOut)));

  // R11: read data is zero after a cycle with no read
  a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> (rdData == '0));

  // R6: two-stage synchronizer delay
  if (SYNC_STAGES == 2) begin : g_sync_chk
    a_r6_sync_delay: assert property (@(posedge clk) disable iff (!rstN)
      (upCnt == 2'd2) |-> (syncIn == $past(padIn, 2)));
  end

endmodule

bind gpio_port gpio_port_chk #(
  .NUM_PINS   (NUM_PINS),
  .ADDR_W     (ADDR_W),
  .SYNC_STAGES(SYNC_STAGES)
) u_chk (.*);

// File: tb/sim_gpio_port.sv
module sim_gpio_port;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [11:0] addr = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic [7:0]  padIn = '0;
  logic [7:0]  padOut, padOe, syncIn;
  logic [7:0]  cfgSense, cfgBoth, cfgEvent, cfgEnable;
  logic [7:0]  intRaw = '0;
  logic [7:0]  intClear;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .padIn(padIn), .padOut(padOut),
    .padOe(padOe), .syncIn(syncIn), .cfgSense(cfgSense), .cfgBoth(cfgBoth),
    .cfgEvent(cfgEvent), .cfgEnable(cfgEnable), .intRaw(intRaw),
    .intClear(intClear)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; addr = '0; wrData = '0;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    d = rdData;
    rdEn = 1'b0; addr = '0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish();
  end

  initial begin
    logic [7:0] rv;
    logic [7:0] lat;
    logic [7:0] dirs [4];
    dirs[0] = 8'h00; dirs[1] = 8'hFF; dirs[2] = 8'hA5; dirs[3] = 8'h3C;
    lat = '0;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 padOe", padOe, 8'h00);
    check("R1 padOut", padOut, 8'h00);
    check("R1 intClear", intClear, 8'h00);
    check("R1 rdData", rdData, 8'h00);
    for (int i = 0; i < 5; i++) begin
      busRead(12'h400 + 12'(4*i), rv);
      check("R1 register reset", rv, 8'h00);
    end

    // R6 synchronizer delay
    @(negedge clk); padIn = 8'hC3;
    @(negedge clk); check("R6 one edge", syncIn, 8'h00);
    @(negedge clk); check("R6 two edges", syncIn, 8'hC3);

    // R2 direction register
    for (int i = 0; i < 4; i++) begin
      busWrite(12'h400, dirs[i] ^ 8'h11);
      check("R2 padOe", padOe, dirs[i] ^ 8'h11);
      busRead(12'h400, rv);
      check("R2 readback", rv, dirs[i] ^ 8'h11);
    end

    // R3 R5 sweep of masks under four direction patterns
    padIn = 8'h96;
    repeat (3) @(negedge clk);
    for (int di = 0; di < 4; di++) begin
      busWrite(12'h400, dirs[di]);
      for (int m = 0; m < 256; m++) begin
        logic [7:0] mk, wd, rm;
        mk = 8'(m);
        wd = 8'(m * 29 + 7 + di * 64);
        busWrite({2'b00, mk, 2'b00}, wd);
        lat = (lat & ~(mk & dirs[di])) | (wd & mk & dirs[di]);
        check("R3 masked write", padOut, lat);
        rm = mk ^ 8'h5A;
        busRead({2'b00, rm, 2'b00}, rv);
        check("R5 masked read", rv, rm & ((dirs[di] & lat) | (~dirs[di] & 8'h96)));
      end
    end

    // R4 writes to input pins ignored, latch kept for later output
    busWrite(12'h400, 8'hFF);
    busWrite(12'h3FC, 8'h0F);
    busWrite(12'h400, 8'h00);
    busWrite(12'h3FC, 8'hF0);
    check("R4 input write ignored", padOut, 8'h0F);
    busWrite(12'h400, 8'hFF);
    check("R4 old latch driven", padOut, 8'h0F);
    busRead(12'h3FC, rv);
    check("R4 read after switch", rv, 8'h0F);

    // R7 configuration registers
    for (int i = 0; i < 4; i++) begin
      busWrite(12'h404 + 12'(4*i), 8'h21 + 8'(i * 17));
    end
    check("R7 sense", cfgSense, 8'h21);
    check("R7 both", cfgBoth, 8'h32);
    check("R7 event", cfgEvent, 8'h43);
    check("R7 enable", cfgEnable, 8'h54);
    for (int i = 0; i < 4; i++) begin
      busRead(12'h404 + 12'(4*i), rv);
      check("R7 readback", rv, 8'h21 + 8'(i * 17));
    end

    // R8 raw and masked status
    intRaw = 8'hE6;
    busRead(12'h414, rv);
    check("R8 raw", rv, 8'hE6);
    busRead(12'h418, rv);
    check("R8 masked", rv, 8'hE6 & 8'h54);
    busWrite(12'h414, 8'hFF);
    busWrite(12'h418, 8'hFF);
    check("R8 write no effect enable", cfgEnable, 8'h54);
    check("R8 write no effect oe", padOe, 8'hFF);
    busRead(12'h418, rv);
    check("R8 masked after write", rv, 8'h44);

    // R9 clear pulse
    busWrite(12'h41C, 8'h9B);
    check("R9 pulse", intClear, 8'h9B);
    @(negedge clk);
    check("R9 pulse ends", intClear, 8'h00);
    busRead(12'h41C, rv);
    check("R9 read zero", rv, 8'h00);

    // R10 unmapped and misaligned offsets
    busWrite(12'h420, 8'h00);
    busWrite(12'h401, 8'h00);
    busWrite(12'h412, 8'h00);
    busWrite(12'h3FD, 8'hF0);
    busWrite(12'hFFC, 8'h00);
    check("R10 oe kept", padOe, 8'hFF);
    check("R10 enable kept", cfgEnable, 8'h54);
    check("R10 out kept", padOut, 8'h0F);
    busRead(12'h420, rv);
    check("R10 read 420", rv, 8'h00);
    busRead(12'h401, rv);
    check("R10 read misaligned", rv, 8'h00);
    busRead(12'h3FE, rv);
    check("R10 read misaligned window", rv, 8'h00);

    // R11 read data returns to zero
    busRead(12'h400, rv);
    check("R11 read value", rv, 8'hFF);
    @(negedge clk);
    check("R11 idle zero", rdData, 8'h00);

    finish();
  end
endmodule